// File: doc/BRIEF.md
# PWM Generator with Duty-Sample FIFO

This block produces one pulse-width-modulated output from a small register bank. Software sets a period, then writes duty samples into a four-entry queue. A counter advances on prescaled ticks of a selected source tick. Each output period lasts the period value plus two ticks. In normal mode the output is high while the counter is below the current sample. A new sample leaves the queue when the block is enabled, and again after every group of 1, 2, 4 or 8 periods.

Software can invert the polarity or disconnect the output. It can also choose among three source tick inputs or stop the count. Sticky status flags record a write to a full queue, compare hits, rollovers and reloads that find the queue empty. Writing 1 to a flag clears it. A self-clearing software reset returns every register and the queue to their reset state.

Registers are read through a registered data port, so a read value appears one cycle after the read strobe. The register offsets are: control at 0x00, status at 0x04, sample at 0x0C and period at 0x10.

Top module: `pwm_fifo_top`

## Requirements
- R1: After reset, control, status, sample and period all read 0, and `pwm_out` is 0.
- R2: One output period lasts (period register + 2) prescaled ticks. In normal mode `pwm_out` is high while the counter value is below the current sample, for exactly min(sample, period+2) ticks of each period. A sample of 0 keeps the output low. A sample of period+2 or more keeps it high.
- R3: Writing 0xFFFF to the period register stores and reads back 0xFFFE. Any other value is stored unchanged.
- R4: Control bits [15:4] hold the division ratio minus one. A field value of N produces one counter tick every N+1 selected source ticks.
- R5: Control bits [19:18] set the output mode. 0 is normal and 1 is inverted, where the output is high for (period+2 − sample) ticks. 2 and 3 hold `pwm_out` at 0.
- R6: Control bits [17:16] choose the tick source. 0 stops the counter. 1, 2 and 3 select `src_tick` bit 0, 1 and 2.
- R7: Control bits [2:1] = n make each sample last 2^n periods. One sample is popped when the enable (bit 0) rises, and another at the end of each group of 2^n periods.
- R8: The queue holds 4 samples. Status bits [2:0] give the number of occupied entries. While the block is disabled, no entry is consumed.
- R9: A sample write while the queue is full is discarded and sets status bit 6. Writing 1 to any of status bits 6..3 clears that flag.
- R10: Status bit 4 is set at each rollover. Status bit 5 is set when the counter equals the current sample on a tick. Status bit 3 is set when a reload finds the queue empty, and the current sample is then kept.
- R11: While the enable bit is 0, `pwm_out` is 0 whatever the polarity. The sample register reads the current sample only while enabled, and reads 0 otherwise.
- R12: Writing 1 to control bit 3 clears the queue and all registers. Bit 3 reads 1 for SWR_CYCLES cycles, then clears itself.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe; `rdata` is valid the next cycle |
| addr | input | 5 | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| src_tick | input | 3 | Tick enables of the three selectable sources |
| pwm_out | output | 1 | Modulated output |

## Verification
The bench measures high time over whole numbers of periods. This exposes an off-by-one in the plus-two period length, in the prescaler ratio, or in the counter-below-sample rule as a wrong count of high cycles. It drives the edge samples 0 and period+2 or more, where a faulty compare would emit a glitch pulse or a false compare flag. It reads the fill level mid-period during a repeat-by-two run, so popping on every period or skipping the pop at enable shows up as a wrong level. It also writes to a full queue, inverts the polarity while disabled and issues a soft reset. A design that overwrote an entry, leaked an inverted high, or failed to flush would show a wrong level, flag or read value.

// File: rtl/pwm_fifo_pkg.sv
package pwm_fifo_pkg;
  localparam int unsigned ADDR_W = 5;
  localparam int unsigned PRE_W  = 12;

  localparam logic [ADDR_W-1:0] OFS_CTRL = 5'h00;
  localparam logic [ADDR_W-1:0] OFS_STAT = 5'h04;
  localparam logic [ADDR_W-1:0] OFS_SAMP = 5'h0C;
  localparam logic [ADDR_W-1:0] OFS_PER  = 5'h10;

  localparam int unsigned SWR_BIT = 3;
  localparam int unsigned ST_FE   = 3;
  localparam int unsigned ST_ROV  = 4;
  localparam int unsigned ST_CMP  = 5;
  localparam int unsigned ST_FWE  = 6;

  typedef enum logic [1:0] {
    OUT_NORMAL = 2'd0,
    OUT_INVERT = 2'd1,
    OUT_OFF    = 2'd2,
    OUT_OFF_B  = 2'd3
  } out_mode_e;

  // field order matches the control word, bit 0 upward from the end
  typedef struct packed {
    out_mode_e        omode;  // [19:18]
    logic [1:0]       src;    // [17:16]
    logic [PRE_W-1:0] presc;  // [15:4]
    logic             swr;    // [3]
    logic [1:0]       rpt;    // [2:1]
    logic             en;     // [0]
  } ctrl_t;

  localparam int unsigned CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/pwm_sample_fifo.sv
module pwm_sample_fifo #(
  parameter  int unsigned DW    = 16,
  parameter  int unsigned DEPTH = 4,
  localparam int unsigned PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [DW-1:0] din,
  input  logic          pop,
  output logic [DW-1:0] dout,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic          do_push, do_pop;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push & ~full;
  assign do_pop  = pop & ~empty;
  assign dout    = mem[rp];

  // storage has no reset so it can map onto RAM
  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (do_push) wp <= bump(wp);
      if (do_pop)  rp <= bump(rp);
      count <= count + CW'(do_push) - CW'(do_pop);
    end
  end
endmodule

// File: rtl/pwm_prescale.sv
module pwm_prescale #(
  parameter int unsigned PRE_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             src_tick,
  input  logic [PRE_W-1:0] div,
  output logic             tick
);
  logic [PRE_W-1:0] cnt;

  assign tick = run & src_tick & (cnt == div);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
    end else if (src_tick) begin
      cnt <= (cnt == div) ? '0 : cnt + 1'b1;
    end
  end
endmodule

// File: rtl/pwm_core.sv
module pwm_core
  import pwm_fifo_pkg::*;
#(
  parameter int unsigned DW    = 16,
  parameter int unsigned RPT_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             tick,
  input  logic [DW-1:0]    period,
  input  logic [RPT_W-1:0] rpt,
  input  out_mode_e        omode,
  input  logic             fifo_empty,
  input  logic [DW-1:0]    fifo_dout,
  output logic             pop,
  output logic [DW-1:0]    cur,
  output logic             roll_ev,
  output logic             cmp_ev,
  output logic             empty_ev,
  output logic             pwm_out
);
  localparam int unsigned REP_W = (1 << RPT_W) - 1;

  logic             en_q;
  logic [DW-1:0]    cnt;
  logic [REP_W-1:0] rep;
  logic [REP_W-1:0] rep_lim;
  logic [DW:0]      last_cnt;
  logic             start, last_rep, reload, level;

  assign rep_lim  = REP_W'((32'd1 << rpt) - 32'd1);
  assign last_cnt = {1'b0, period} + 1'b1;
  assign start    = en & ~en_q;
  assign roll_ev  = en & en_q & tick & ({1'b0, cnt} >= last_cnt);
  assign last_rep = (rep == rep_lim);
  assign reload   = start | (roll_ev & last_rep);
  assign pop      = reload & ~fifo_empty;
  assign empty_ev = reload & fifo_empty;
  assign cmp_ev   = en & en_q & tick & (cnt == cur);

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q <= 1'b0;
      cnt  <= '0;
      rep  <= '0;
      cur  <= '0;
    end else if (!en) begin
      en_q <= 1'b0;
      cnt  <= '0;
      rep  <= '0;
    end else begin
      en_q <= 1'b1;
      if (start) begin
        cnt <= '0;
        rep <= '0;
      end else if (tick) begin
        if (roll_ev) begin
          cnt <= '0;
          rep <= last_rep ? '0 : rep + 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
      if (pop) cur <= fifo_dout;
    end
  end

  always_comb begin
    unique case (omode)
      OUT_NORMAL: level = (cnt < cur);
      OUT_INVERT: level = ~(cnt < cur);
      default:    level = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) pwm_out <= 1'b0;
    else     pwm_out <= en & level;
  end
endmodule

// File: rtl/pwm_fifo_top.sv
module pwm_fifo_top
  import pwm_fifo_pkg::*;
#(
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned SAMPLE_W   = 16,
  parameter int unsigned FIFO_DEPTH = 4,
  parameter int unsigned SWR_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic [2:0]        src_tick,
  output logic              pwm_out
);
  localparam int unsigned CW    = $clog2(FIFO_DEPTH + 1);
  localparam int unsigned SWR_W = $clog2(SWR_CYCLES + 1);

  ctrl_t               ctrl_q, ctrl_wr, ctrl_rd;
  logic [SAMPLE_W-1:0] period_q, period_wr;
  logic                f_fwe, f_cmp, f_rov, f_fe;
  logic [SWR_W-1:0]    swr_cnt;
  logic                swr_busy, irst;
  logic                wr_ctrl, wr_stat, wr_samp, wr_per, swr_req;
  logic                sel_tick, pre_tick;
  logic                fifo_push, fifo_pop, fifo_full, fifo_empty;
  logic [SAMPLE_W-1:0] fifo_dout, cur;
  logic [CW-1:0]       fifo_count;
  logic                roll_ev, cmp_ev, empty_ev, fwe_ev;
  logic [DATA_W-1:0]   stat_word, rd_mux;
  logic                en_w, off_w;

  assign en_w     = ctrl_q.en;
  assign off_w    = ctrl_q.omode[1];
  assign swr_busy = (swr_cnt != '0);
  assign irst     = rst | swr_busy;

  assign wr_ctrl  = wr_en & (addr == OFS_CTRL);
  assign wr_stat  = wr_en & (addr == OFS_STAT);
  assign wr_samp  = wr_en & (addr == OFS_SAMP);
  assign wr_per   = wr_en & (addr == OFS_PER);
  assign swr_req  = wr_ctrl & wdata[SWR_BIT];

  assign fifo_push = wr_samp & ~fifo_full & ~swr_busy;
  assign fwe_ev    = wr_samp & fifo_full & ~swr_busy;

  always_comb begin
    ctrl_wr     = ctrl_t'(wdata[CTRL_W-1:0]);
    ctrl_wr.swr = 1'b0;
    period_wr   = (wdata[SAMPLE_W-1:0] == '1) ? ('1 - 1'b1) : wdata[SAMPLE_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst)                      swr_cnt <= '0;
    else if (swr_req & ~swr_busy) swr_cnt <= SWR_W'(SWR_CYCLES);
    else if (swr_busy)            swr_cnt <= swr_cnt - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (irst) begin
      ctrl_q   <= '0;
      period_q <= '0;
      f_fwe    <= 1'b0;
      f_cmp    <= 1'b0;
      f_rov    <= 1'b0;
      f_fe     <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl_q   <= swr_req ? '0 : ctrl_wr;
      if (wr_per)  period_q <= period_wr;
      f_fwe <= (f_fwe & ~(wr_stat & wdata[ST_FWE])) | fwe_ev;
      f_cmp <= (f_cmp & ~(wr_stat & wdata[ST_CMP])) | cmp_ev;
      f_rov <= (f_rov & ~(wr_stat & wdata[ST_ROV])) | roll_ev;
      f_fe  <= (f_fe  & ~(wr_stat & wdata[ST_FE]))  | empty_ev;
    end
  end

  always_comb begin
    unique case (ctrl_q.src)
      2'd1:    sel_tick = src_tick[0];
      2'd2:    sel_tick = src_tick[1];
      2'd3:    sel_tick = src_tick[2];
      default: sel_tick = 1'b0;
    endcase
  end

  pwm_prescale #(.PRE_W(PRE_W)) u_pre (
    .clk      (clk),
    .rst      (irst),
    .run      (ctrl_q.en),
    .src_tick (sel_tick),
    .div      (ctrl_q.presc),
    .tick     (pre_tick)
  );

  pwm_sample_fifo #(.DW(SAMPLE_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk   (clk),
    .rst   (irst),
    .push  (fifo_push),
    .din   (wdata[SAMPLE_W-1:0]),
    .pop   (fifo_pop),
    .dout  (fifo_dout),
    .count (fifo_count),
    .full  (fifo_full),
    .empty (fifo_empty)
  );

  pwm_core #(.DW(SAMPLE_W), .RPT_W(2)) u_core (
    .clk        (clk),
    .rst        (irst),
    .en         (ctrl_q.en),
    .tick       (pre_tick),
    .period     (period_q),
    .rpt        (ctrl_q.rpt),
    .omode      (ctrl_q.omode),
    .fifo_empty (fifo_empty),
    .fifo_dout  (fifo_dout),
    .pop        (fifo_pop),
    .cur        (cur),
    .roll_ev    (roll_ev),
    .cmp_ev     (cmp_ev),
    .empty_ev   (empty_ev),
    .pwm_out    (pwm_out)
  );

  always_comb begin
    stat_word           = '0;
    stat_word[CW-1:0]   = fifo_count;
    stat_word[ST_FE]    = f_fe;
    stat_word[ST_ROV]   = f_rov;
    stat_word[ST_CMP]   = f_cmp;
    stat_word[ST_FWE]   = f_fwe;
    ctrl_rd             = ctrl_q;
    ctrl_rd.swr         = swr_busy;
    unique case (addr)
      OFS_CTRL: rd_mux = DATA_W'(ctrl_rd);
      OFS_STAT: rd_mux = stat_word;
      OFS_SAMP: rd_mux = ctrl_q.en ? DATA_W'(cur) : '0;
      OFS_PER:  rd_mux = DATA_W'(period_q);
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end
endmodule

// File: rtl/pwm_fifo_chk.sv
module pwm_fifo_chk #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned CW    = 3
) (
  input logic          clk,
  input logic          rst,
  input logic          en,
  input logic          off,
  input logic          pwm_out,
  input logic          wr_samp,
  input logic          full,
  input logic          pop,
  input logic [CW-1:0] count,
  input logic          fwe,
  input logic          swr_busy
);
  // R11: disabled output is low one cycle later
  assert_low_when_off_R11: assert property (@(posedge clk) disable iff (rst)
    !en |=> !pwm_out);

  // R5: disconnected mode forces the output low
  assert_mode_off_R5: assert property (@(posedge clk) disable iff (rst)
    off |=> !pwm_out);

  // R8: fill level bounded by the depth
  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));

  // R9: write to a full queue raises the error flag
  assert_full_flag_R9: assert property (@(posedge clk) disable iff (rst)
    (wr_samp && full && !swr_busy) |=> fwe);

  // R9: write to a full queue with no pop leaves it full
  assert_full_keeps_R9: assert property (@(posedge clk) disable iff (rst)
    (wr_samp && full && !pop && !swr_busy) |=> (count == CW'(DEPTH)));

  // R12: soft reset flushes the queue
  assert_swr_flush_R12: assert property (@(posedge clk) disable iff (rst)
    swr_busy |=> (count == '0));
endmodule

bind pwm_fifo_top pwm_fifo_chk #(.DEPTH(FIFO_DEPTH), .CW(CW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .en       (en_w),
  .off      (off_w),
  .pwm_out  (pwm_out),
  .wr_samp  (wr_samp),
  .full     (fifo_full),
  .pop      (fifo_pop),
  .count    (fifo_count),
  .fwe      (f_fwe),
  .swr_busy (swr_busy)
);

// File: tb/tb_pwm_fifo_top.sv
`timescale 1ns/1ps
module tb_pwm_fifo_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [2:0]  src_tick = 3'b011;
  logic        pwm_out;
  int          total = 0, bad = 0;
  int unsigned phase = 0;

  localparam logic [4:0] A_CTRL = 5'h00, A_STAT = 5'h04, A_SAMP = 5'h0C, A_PER = 5'h10;

  always #2.5 clk = ~clk;

  pwm_fifo_top dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .src_tick(src_tick), .pwm_out(pwm_out)
  );

  // slow source: bit 2 pulses once every 4 cycles
  initial begin
    forever begin
      @(negedge clk);
      phase = phase + 1;
      src_tick = {(phase % 4) == 0, 2'b11};
    end
  end

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic count_high(input int n, output int h);
    h = 0;
    repeat (n) begin
      @(negedge clk);
      h += int'(pwm_out);
    end
  endtask

  function automatic logic [31:0] mk(input int en, input int rpt, input int presc,
                                     input int src, input int om);
    return 32'((om << 18) | (src << 16) | (presc << 4) | (rpt << 1) | en);
  endfunction

  function automatic int exp_high(input int per, input int s, input int d,
                                  input int inv, input int periods);
    int len = per + 2;
    int hi  = (s < len) ? s : len;
    return inv ? periods * d * (len - hi) : periods * d * hi;
  endfunction

  task automatic configure(input int per, input int s, input logic [31:0] cw);
    wr(A_CTRL, 32'h8);
    repeat (8) @(negedge clk);
    wr(A_PER, 32'(per));
    wr(A_SAMP, 32'(s));
    wr(A_CTRL, cw);
  endtask

  initial begin
    #(200000 * 5);
    bad++; total++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int h;
    int r;
    r = int'($urandom(32'd4242));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk("R1 pwm_out", {31'd0, pwm_out}, 0);
    rd(A_CTRL, v); chk("R1 ctrl", v, 0);
    rd(A_STAT, v); chk("R1 stat", v, 0);
    rd(A_SAMP, v); chk("R1 samp", v, 0);
    rd(A_PER, v);  chk("R1 per", v, 0);

    // R3 period clamp
    wr(A_PER, 32'hFFFF); rd(A_PER, v); chk("R3 clamp", v, 32'hFFFE);
    wr(A_PER, 32'h5);    rd(A_PER, v); chk("R3 plain", v, 32'h5);

    // R8 / R9 fill, overflow, W1C; R11 sample read disabled
    wr(A_SAMP, 1); wr(A_SAMP, 2);
    rd(A_STAT, v); chk("R8 count2", v, 2);
    wr(A_SAMP, 3); wr(A_SAMP, 4);
    rd(A_STAT, v); chk("R8 count4", v, 4);
    wr(A_SAMP, 9);
    rd(A_STAT, v); chk("R9 full write", v, 32'h44);
    rd(A_SAMP, v); chk("R11 samp disabled", v, 0);
    wr(A_STAT, 32'h40);
    rd(A_STAT, v); chk("R9 w1c", v, 4);

    // R12 soft reset
    wr(A_CTRL, 32'h8);
    rd(A_CTRL, v); chk("R12 busy bit", v, 32'h8);
    repeat (8) @(negedge clk);
    rd(A_CTRL, v); chk("R12 self clear", v, 0);
    rd(A_STAT, v); chk("R12 flushed", v, 0);
    rd(A_PER, v);  chk("R12 per cleared", v, 0);

    // R2 normal duty, R10 flags, R11 sample read enabled
    configure(8, 3, mk(1, 0, 0, 1, 0));
    repeat (20) @(negedge clk);
    count_high(30, h); chk("R2 duty 3/10", 32'(h), 9);
    rd(A_SAMP, v); chk("R11 samp enabled", v, 3);
    rd(A_STAT, v); chk("R10 flags", v, 32'h38);

    // R11 inverted but disabled stays low; R5 inverted when enabled
    configure(8, 3, mk(0, 0, 0, 1, 1));
    count_high(20, h); chk("R11 disabled inverted", 32'(h), 0);
    wr(A_CTRL, mk(1, 0, 0, 1, 1));
    repeat (20) @(negedge clk);
    count_high(30, h); chk("R5 inverted", 32'(h), 21);

    // R5 disconnected
    configure(8, 3, mk(1, 0, 0, 1, 2));
    repeat (20) @(negedge clk);
    count_high(30, h); chk("R5 off mode", 32'(h), 0);

    // R4 prescaler divide by 3
    configure(2, 1, mk(1, 0, 2, 1, 0));
    repeat (24) @(negedge clk);
    count_high(36, h); chk("R4 prescale", 32'(h), 9);

    // R6 source off freezes the counter
    configure(8, 3, mk(1, 0, 0, 0, 0));
    repeat (10) @(negedge clk);
    wr(A_STAT, 32'h78);
    count_high(40, h); chk("R6 src off level", 32'(h), 40);
    rd(A_STAT, v); chk("R6 src off no rollover", v & 32'h10, 0);

    // R6 slow source on bit 2
    configure(2, 1, mk(1, 0, 0, 3, 0));
    repeat (32) @(negedge clk);
    count_high(64, h); chk("R6 src3", 32'(h), 16);

    // R7 repeat by two, fill level mid-period
    wr(A_CTRL, 32'h8);
    repeat (8) @(negedge clk);
    wr(A_PER, 8);
    wr(A_SAMP, 2); wr(A_SAMP, 4); wr(A_SAMP, 6);
    wr(A_CTRL, mk(1, 1, 0, 1, 0));
    repeat (9) @(negedge clk);
    rd(A_STAT, v); chk("R7 after start", v & 32'h7, 2);
    repeat (18) @(negedge clk);
    rd(A_STAT, v); chk("R7 after group1", v & 32'h7, 1);
    repeat (18) @(negedge clk);
    rd(A_STAT, v); chk("R7 after group2", v & 32'hF, 0);
    repeat (18) @(negedge clk);
    rd(A_STAT, v); chk("R10 empty reload", v & 32'h8, 32'h8);
    rd(A_SAMP, v); chk("R10 keeps sample", v, 6);

    // R2 edge samples, R10 no compare when sample is out of range
    configure(8, 0, mk(1, 0, 0, 1, 0));
    repeat (20) @(negedge clk);
    count_high(30, h); chk("R2 zero sample", 32'(h), 0);
    configure(8, 15, mk(1, 0, 0, 1, 0));
    repeat (12) @(negedge clk);
    wr(A_STAT, 32'h78);
    count_high(30, h); chk("R2 full sample", 32'(h), 30);
    rd(A_STAT, v); chk("R10 no compare", v & 32'h30, 32'h10);

    // random mix of period, sample, prescale and polarity
    for (int i = 0; i < 12; i++) begin
      int per = int'($urandom_range(0, 12));
      int s   = int'($urandom_range(0, 15));
      int pr  = int'($urandom_range(0, 3));
      int inv = int'($urandom_range(0, 1));
      int win = 3 * (per + 2) * (pr + 1);
      configure(per, s, mk(1, 0, pr, 1, inv));
      repeat (2 * (per + 2) * (pr + 1) + 4) @(negedge clk);
      count_high(win, h);
      chk(inv ? "R5 random inverted" : "R2 R4 random", 32'(h),
          32'(exp_high(per, s, pr + 1, inv, 3)));
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule